// File: doc/BRIEF.md
# Board LED Driver with Status Override

This block drives a row of board LEDs from one of two sources. Normally the LEDs follow an 8-bit register that software writes through a simple register port. A control bit switches the LEDs to show eight processor status signals instead. A status event may last only one clock, so each status line passes through its own pulse stretcher. The stretcher holds the LED on for a set number of cycles, which makes a brief event visible as a flash.

The register port is a single-cycle write strobe with a word index and a data word. The read data is combinational on the index. Two word indices are decoded, one for the LED value and one for the control word. Status lane i drives LED i. Lanes 0 to 7 carry, in order: sleeping, deep sleep, halted, lockup, system reset request, transmit event, wakeup, and debug restarted.

Top module: `led_status_panel`

## Requirements
- R1: After reset, `led_o` is 0x00, the LED word reads 0x00000000 and the control word reads 0x00000000.
- R2: A write to word index `LED_IDX` stores `wdata_i[7:0]`. A read at that index returns the stored byte in bits 7:0, and bits 31:8 read as 0.
- R3: While the control bit (control word bit 0) is 0, `led_o` equals the stored LED byte from the clock edge after each LED write. Activity on `status_i` has no effect on `led_o`.
- R4: While the control bit is 1, `led_o[i]` shows the stretched form of `status_i[i]`. Lane 0 is sleeping, 1 deep sleep, 2 halted, 3 lockup, 4 system reset request, 5 transmit event, 6 wakeup, and 7 debug restarted.
- R5: A status input that is high for one sampling edge makes its stretched output high for exactly `STRETCH_CYC` cycles after that edge, and low after that.
- R6: Each edge that samples a status input high restarts the stretch. An input held high keeps its output high, and the output falls `STRETCH_CYC` cycles after the last edge that sampled the input high.
- R7: A write to the control bit takes effect on `led_o` at the next clock edge. It leaves the stored LED byte unchanged, so returning to normal mode shows the earlier value again.
- R8: An LED write made in override mode updates the stored byte, which can be read back, and does not change `led_o`.
- R9: The control word keeps only bit 0. Bits 31:1 of a write to it are ignored and read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W | Word index for the write and the read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| status_i | input | LANES | Processor status lines, in lane order as in R4 |
| led_o | output | LANES | LED drive, 1 means lit |

## Verification
The assertions assume that `status_i` and the register port hold still around each clock edge. They also assume that a status pulse sampled while the stretcher is already running only restarts it. The bench changes every input half a cycle away from the sampling edge. It never drives a write and a change of the control bit in the same cycle. Before it checks a fresh stretch window, it waits until every stretcher has run down, so each expected on and off cycle depends on a single pulse.

// File: rtl/led_ovr_pkg.sv
package led_ovr_pkg;

   // Status lane order; lane i drives LED i in override mode.
   typedef enum logic [2:0] {
      LN_SLEEP       = 3'd0,
      LN_DEEP_SLEEP  = 3'd1,
      LN_HALTED      = 3'd2,
      LN_LOCKUP      = 3'd3,
      LN_RESET_REQ   = 3'd4,
      LN_TX_EVENT    = 3'd5,
      LN_WAKEUP      = 3'd6,
      LN_DBG_RESTART = 3'd7
   } lane_e;

   localparam int unsigned NUM_STATUS = 8;

   // Width of a counter able to hold the value n.
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/led_ovr_stretch.sv
module led_ovr_stretch
   import led_ovr_pkg::*;
#(
   parameter int unsigned HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   output logic lit_o
);

   localparam int unsigned CW = cnt_width(HOLD);

   generate
      if (HOLD == 0) begin : g_pass
         // No stretch requested: the lane passes straight through.
         wire unused_pass = clk ^ rst_n;
         assign lit_o = pulse_i;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (pulse_i) begin
               cnt_q <= CW'(HOLD);
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign lit_o = (cnt_q != '0);

         // R5: an input sampled high is lit on the following cycle
         p_catch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_i |=> lit_o);

         // R5: the output never rises without a sampled input
         p_no_spont_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lit_o) |-> $past(pulse_i));

         // R6: the output only drops after an edge that saw the input low
         p_fall_when_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(lit_o) |-> !$past(pulse_i));
      end
   endgenerate

endmodule

// File: rtl/led_ovr_regs.sv
module led_ovr_regs #(
   parameter int unsigned LANES    = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned LED_IDX  = 0,
   parameter int unsigned CTRL_IDX = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [LANES-1:0]  leds_q_o,
   output logic              ovr_q_o
);

   localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(LED_IDX);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_IDX);

   logic hit_led, hit_ctrl;
   assign hit_led  = (addr_i == A_LED);
   assign hit_ctrl = (addr_i == A_CTRL);

   // Only the low bits of a write land anywhere; the rest is dropped.
   wire unused_wdata_hi = ^wdata_i[DATA_W-1:LANES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         leds_q_o <= '0;
         ovr_q_o  <= 1'b0;
      end else if (wr_en_i) begin
         if (hit_led)  leds_q_o <= wdata_i[LANES-1:0];
         if (hit_ctrl) ovr_q_o  <= wdata_i[0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_led)       rdata_o[LANES-1:0] = leds_q_o;
      else if (hit_ctrl) rdata_o[0]         = ovr_q_o;
   end

   // R7: writing the control word never disturbs the LED byte
   p_ctrl_keeps_leds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && hit_ctrl) |=> $stable(leds_q_o));

   // R9: the control bit moves only on a write to its own index
   p_ovr_only_by_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && hit_ctrl) |=> $stable(ovr_q_o));

endmodule

// File: rtl/led_status_panel.sv
module led_status_panel
   import led_ovr_pkg::*;
#(
   parameter int unsigned LANES       = NUM_STATUS,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned LED_IDX     = 0,
   parameter int unsigned CTRL_IDX    = 1,
   parameter int unsigned STRETCH_CYC = 2_500_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [LANES-1:0]  status_i,
   output logic [LANES-1:0]  led_o
);

   localparam logic [ADDR_W-1:0] A_LED  = ADDR_W'(LED_IDX);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_IDX);

   generate
      if (LANES != NUM_STATUS) begin : g_bad_lanes
         $error("LANES must match the number of status lanes");
      end
      if (LANES >= DATA_W) begin : g_bad_width
         $error("DATA_W must exceed LANES");
      end
      if (LED_IDX == CTRL_IDX) begin : g_bad_map
         $error("LED and control indices must differ");
      end
      if ((LED_IDX >> ADDR_W) != 0 || (CTRL_IDX >> ADDR_W) != 0) begin : g_bad_addr
         $error("register index does not fit in ADDR_W");
      end
   endgenerate

   logic [LANES-1:0] leds_q;
   logic             ovr_q;
   logic [LANES-1:0] lit;

   led_ovr_regs #(
      .LANES   (LANES),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .LED_IDX (LED_IDX),
      .CTRL_IDX(CTRL_IDX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .leds_q_o(leds_q),
      .ovr_q_o (ovr_q)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      led_ovr_stretch #(.HOLD(STRETCH_CYC)) u_stretch (
         .clk    (clk),
         .rst_n  (rst_n),
         .pulse_i(status_i[i]),
         .lit_o  (lit[i])
      );
   end

   assign led_o = ovr_q ? lit : leds_q;

   logic ctrl_wr, led_wr;
   assign ctrl_wr = wr_en_i && (addr_i == A_CTRL);
   assign led_wr  = wr_en_i && (addr_i == A_LED);

   // R3: in normal mode a LED write shows on the pins one edge later
   p_normal_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_q && !ctrl_wr && led_wr) |=> (led_o == $past(wdata_i[LANES-1:0])));

   // R3: in normal mode, with no write, the pins hold whatever status does
   p_normal_ignores_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_q && !wr_en_i) |=> $stable(led_o));

   // R4: in override mode every sampled status lane is lit next cycle
   p_override_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !ctrl_wr) |=> ((led_o & $past(status_i)) == $past(status_i)));

   // R8: a LED write in override mode leaves the pins to the stretchers
   p_override_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && led_wr && status_i == '0 && led_o == '0) |=> (led_o == '0));

endmodule

// File: tb/led_status_panel_bench.sv
module led_status_panel_bench;

   localparam int S = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [7:0]  status = '0;
   logic [7:0]  led;

   always #10 clk = ~clk;

   led_status_panel #(.STRETCH_CYC(S)) u_led_status_panel (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .status_i(status), .led_o(led)
   );

   typedef struct {
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Monitor: compares every queued expectation against the ports.
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = q.pop_front();
            act = it.is_rd ? rdata : {24'b0, led};
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s %s actual=%h expected=%h", it.tag,
                        it.is_rd ? "read" : "led", act, it.exp);
            end
         end
      end
   end

   task automatic exp_led(input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk); #1;
      it.is_rd = 0; it.exp = {24'b0, e}; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      addr = a; #1;
      it.is_rd = 1; it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m, input int edges);
      @(negedge clk);
      status = m;
      repeat (edges) @(posedge clk);
      #1 status = '0;
   endtask

   // Expect m lit for S checks after the last sampling edge, then dark.
   task automatic window(input logic [7:0] m, input string tag);
      for (int k = 0; k < S; k++) exp_led(m, tag);
      exp_led(8'h00, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      exp_led(8'h00, "R1");
      exp_rd(4'd0, 32'h0, "R1");
      exp_rd(4'd1, 32'h0, "R1");

      wr(4'd0, 32'hFFFF_FFA5);
      exp_rd(4'd0, 32'h0000_00A5, "R2");
      exp_led(8'hA5, "R3");

      pulse(8'hFF, 1);
      for (int k = 0; k < S + 3; k++) exp_led(8'hA5, "R3");

      wr(4'd1, 32'hFFFF_FFFE);
      exp_rd(4'd1, 32'h0, "R9");
      exp_led(8'hA5, "R9");

      wr(4'd1, 32'h1);
      exp_led(8'h00, "R7");
      exp_rd(4'd1, 32'h1, "R7");
      exp_rd(4'd0, 32'h0000_00A5, "R7");

      wr(4'd0, 32'h3C);
      exp_led(8'h00, "R8");
      exp_rd(4'd0, 32'h0000_003C, "R8");

      pulse(8'h01, 1);
      window(8'h01, "R5");

      for (int i = 0; i < 8; i++) begin
         pulse(8'(1 << i), 1);
         window(8'(1 << i), "R4");
      end
      pulse(8'h81, 1);
      window(8'h81, "R4");

      pulse(8'h80, 5);
      window(8'h80, "R6");

      wr(4'd1, 32'h0);
      exp_led(8'h3C, "R7");
      exp_rd(4'd0, 32'h0000_003C, "R7");

      repeat (3) @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1-watchdog run did not finish actual=hung expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule